// File: doc/BRIEF.md
# Broadcast Kernel Sequencer

This block drives a row of identical arithmetic lanes that all execute one kernel together. A scalar controller hands it a command made of a start address and the number of stream records in the current block. The sequencer then walks a local store of wide microinstructions and puts one word per cycle on a single broadcast bus that every lane decodes in the same cycle. Each pass through the kernel body covers one record per lane, so a block of N records takes ceil(N / LANES) passes.

The end of the kernel body is marked by the most significant bit of a microinstruction. When a marked word issues and records remain beyond the lanes served by the current pass, the next fetch returns to the start address that was saved when the command was accepted. Otherwise that word is the last of the kernel, and a one-cycle completion pulse follows. On the last pass, a per-lane enable vector switches off the lanes that have no record left. The store is loaded through its own write port. Its read is combinational, so sequencing decisions take effect in the cycle after the word is read.

Top module: `kernel_sequencer`

## Requirements
- R1: After reset, `cmd_ready` is 1 and `bc_valid` and `done` are 0.
- R2: A word written through the store write port at an address is the exact word later broadcast when the kernel reaches that address.
- R3: The first word of an accepted command, read from the start address, appears on `bc_word` with `bc_valid` high in the second cycle after the accepting clock edge. Words without the end-of-body bit are followed by the word at the next address, one per cycle, with no gaps.
- R4: Bit UIW-1 of a microinstruction is the end-of-body flag. When it issues and more than LANES records remain, the next broadcast word comes from the saved start address.
- R5: A command with record count N > 0 makes exactly ceil(N / LANES) passes through the kernel body.
- R6: `bc_lane_en` bit i enables lane i. It is all ones while at least LANES records remain. On the last pass only bits 0 to R-1 are set, where R is the number of records remaining.
- R7: `cmd_ready` is 0 from the accepting edge until the cycle in which `done` is high. A command offered during that window is not taken.
- R8: `done` is high for exactly one cycle, the cycle right after the last word's broadcast cycle. `bc_valid` is 0 in that cycle.
- R9: A command with record count 0 produces no broadcast. `done` pulses in the second cycle after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Kernel command offered |
| cmd_ready | output | 1 | Sequencer can take a command |
| cmd_start | input | AW | Start and loop address of the kernel body |
| cmd_count | input | CNT_W | Records in the current stream block |
| cs_wr_en | input | 1 | Control store write strobe |
| cs_wr_addr | input | AW | Control store write address |
| cs_wr_data | input | UIW | Microinstruction to store |
| bc_valid | output | 1 | Broadcast word is valid this cycle |
| bc_word | output | UIW | Microinstruction shared by all lanes |
| bc_lane_en | output | LANES | Per-lane enable for this word |
| done | output | 1 | One-cycle kernel completion pulse |

## Verification
A table of kernels is run back to back. The table varies body length (one to five words) and record count: an exact multiple of the lane count, remainders of one and four, fewer records than lanes, and a count that needs several passes. Together these cases separate a correct loop-back from falling through to the next address, an off-by-one in the pass count, and a wrong partial mask. Every broadcast word is compared in full against a shadow of what was written, so the address order and the store contents are checked in the same comparison. Directed cases cover the reset state, a zero-record command, a store rewrite between kernels, and the ready/done handshake around each kernel boundary.

// File: rtl/kseq_pkg.sv
// Shared types for the kernel sequencer.
// Assumes: nothing beyond a two-state sequencing model.
package kseq_pkg;
    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_t;
endpackage

// File: rtl/kseq_store.sv
// Microinstruction control store: one synchronous write port for loading and
// one combinational read port for the sequencer.
// Assumes: loads and kernel execution are arranged by the scalar side, so a
// location is never written in the same cycle it is being executed.
module kseq_store #(
    parameter int UIW   = 576,
    parameter int DEPTH = 2048,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic           clk,
    input  logic           wr_en,
    input  logic [AW-1:0]  wr_addr,
    input  logic [UIW-1:0] wr_data,
    input  logic [AW-1:0]  rd_addr,
    output logic [UIW-1:0] rd_data
);
    logic [UIW-1:0] mem [DEPTH];

    // load port: store one microinstruction per write strobe
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    // fetch port: word at the sequencer address, same cycle
    always_comb rd_data = mem[rd_addr];
endmodule

// File: rtl/kseq_lanes.sv
// Lane enable generator: turns the count of records still to process into a
// per-lane enable vector and flags whether another pass will follow.
// Assumes: remain > 0 whenever the outputs are used.
module kseq_lanes #(
    parameter int LANES = 8,
    parameter int CW    = 16
) (
    input  logic [CW-1:0]    remain,
    output logic [LANES-1:0] lane_en,
    output logic             more
);
    // one comparator per lane: lane i has work if more than i records remain
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_en[i] = (remain > CW'(i));
    end

    // another pass is needed if this one cannot cover all remaining records
    assign more = (remain > CW'(LANES));
endmodule

// File: rtl/kseq_issue.sv
// Broadcast register stage: registers the fetched word and lane mask onto the
// shared bus and produces the completion pulse one cycle after the final word.
// Assumes: finish is asserted at most once per kernel, never on back-to-back cycles.
module kseq_issue #(
    parameter int UIW   = 576,
    parameter int LANES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue,
    input  logic             finish,
    input  logic [UIW-1:0]   word,
    input  logic [LANES-1:0] lane_en,
    output logic             bc_valid,
    output logic [UIW-1:0]   bc_word,
    output logic [LANES-1:0] bc_lane_en,
    output logic             fin_pend,
    output logic             done
);
    // broadcast register: capture the fetched word for all lanes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bc_valid   <= 1'b0;
            bc_word    <= '0;
            bc_lane_en <= '0;
        end else begin
            bc_valid <= issue;
            if (issue) begin
                bc_word    <= word;
                bc_lane_en <= lane_en;
            end
        end
    end

    // completion: mark the final issue, then pulse done one cycle later
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fin_pend <= 1'b0;
            done     <= 1'b0;
        end else begin
            fin_pend <= finish;
            done     <= fin_pend;
        end
    end

    // R6
    lanes_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bc_valid |-> (bc_lane_en != '0));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !bc_valid);
endmodule

// File: rtl/kernel_sequencer.sv
// Kernel sequencer top: accepts a kernel command, walks the control store one
// microinstruction per cycle, loops back over the kernel body until all records
// of the block are covered LANES at a time, and reports completion.
// Assumes: every kernel body ends with a word whose bit UIW-1 is set.
module kernel_sequencer
    import kseq_pkg::*;
#(
    parameter int LANES    = 8,
    parameter int UIW      = 576,
    parameter int CS_DEPTH = 2048,
    parameter int CNT_W    = 16,
    localparam int AW      = $clog2(CS_DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic [AW-1:0]    cmd_start,
    input  logic [CNT_W-1:0] cmd_count,
    input  logic             cs_wr_en,
    input  logic [AW-1:0]    cs_wr_addr,
    input  logic [UIW-1:0]   cs_wr_data,
    output logic             bc_valid,
    output logic [UIW-1:0]   bc_word,
    output logic [LANES-1:0] bc_lane_en,
    output logic             done
);
    localparam int END_BIT = UIW - 1;

    seq_state_t       state;
    logic [AW-1:0]    pc;
    logic [AW-1:0]    loop_pc;
    logic [CNT_W-1:0] remain;
    logic [UIW-1:0]   fetch_word;
    logic [LANES-1:0] lane_en;
    logic             more;
    logic             fin_pend;
    logic             accept;
    logic             issue;
    logic             body_end;
    logic             last_issue;
    logic             finish;

    kseq_store #(.UIW(UIW), .DEPTH(CS_DEPTH)) u_store (
        .clk     (clk),
        .wr_en   (cs_wr_en),
        .wr_addr (cs_wr_addr),
        .wr_data (cs_wr_data),
        .rd_addr (pc),
        .rd_data (fetch_word)
    );

    kseq_lanes #(.LANES(LANES), .CW(CNT_W)) u_lanes (
        .remain  (remain),
        .lane_en (lane_en),
        .more    (more)
    );

    kseq_issue #(.UIW(UIW), .LANES(LANES)) u_issue (
        .clk        (clk),
        .rst_n      (rst_n),
        .issue      (issue),
        .finish     (finish),
        .word       (fetch_word),
        .lane_en    (lane_en),
        .bc_valid   (bc_valid),
        .bc_word    (bc_word),
        .bc_lane_en (bc_lane_en),
        .fin_pend   (fin_pend),
        .done       (done)
    );

    // handshake and issue decisions for this cycle
    always_comb begin
        cmd_ready  = (state == SEQ_IDLE) && !fin_pend;
        accept     = cmd_valid && cmd_ready;
        issue      = (state == SEQ_RUN);
        body_end   = fetch_word[END_BIT];
        last_issue = issue && body_end && !more;
        finish     = last_issue || (accept && (cmd_count == '0));
    end

    // sequencing: load a command, step or loop the address, count passes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= SEQ_IDLE;
            pc      <= '0;
            loop_pc <= '0;
            remain  <= '0;
        end else begin
            case (state)
                SEQ_IDLE: begin
                    if (accept) begin
                        pc      <= cmd_start;
                        loop_pc <= cmd_start;
                        remain  <= cmd_count;
                        if (cmd_count != '0) state <= SEQ_RUN;
                    end
                end
                SEQ_RUN: begin
                    if (body_end) begin
                        if (more) begin
                            pc     <= loop_pc;
                            remain <= remain - CNT_W'(LANES);
                        end else begin
                            state <= SEQ_IDLE;
                        end
                    end else begin
                        pc <= pc + 1'b1;
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    // R7
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bc_valid |-> !cmd_ready);

    // R3
    first_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (cmd_count != '0)) |=> ##1 bc_valid);

    // R9
    zero_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (cmd_count == '0)) |=> !bc_valid ##1 (done && !bc_valid));
endmodule

// File: tb/kernel_sequencer_tb.sv
module kernel_sequencer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int LANES = 8;
    localparam int UIW   = 16;
    localparam int DEPTH = 64;
    localparam int CNT_W = 10;
    localparam int AW    = $clog2(DEPTH);
    localparam int NVEC  = 6;
    // each entry: {start[7:0], body length[7:0], record count[15:0]}
    localparam logic [31:0] VEC [NVEC] = '{
        {8'd0,  8'd3, 16'd8},
        {8'd4,  8'd2, 16'd20},
        {8'd8,  8'd1, 16'd1},
        {8'd10, 8'd4, 16'd17},
        {8'd20, 8'd5, 16'd16},
        {8'd30, 8'd2, 16'd7}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic cmd_ready;
    logic [AW-1:0] cmd_start = '0;
    logic [CNT_W-1:0] cmd_count = '0;
    logic cs_wr_en = 1'b0;
    logic [AW-1:0] cs_wr_addr = '0;
    logic [UIW-1:0] cs_wr_data = '0;
    logic bc_valid;
    logic [UIW-1:0] bc_word;
    logic [LANES-1:0] bc_lane_en;
    logic done;

    logic [UIW-1:0] shadow [DEPTH];
    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit ended = 1'b0;

    kernel_sequencer #(.LANES(LANES), .UIW(UIW), .CS_DEPTH(DEPTH), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_start(cmd_start), .cmd_count(cmd_count), .cs_wr_en(cs_wr_en),
        .cs_wr_addr(cs_wr_addr), .cs_wr_data(cs_wr_data), .bc_valid(bc_valid),
        .bc_word(bc_word), .bc_lane_en(bc_lane_en), .done(done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000 && !ended) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            finish_run();
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic write_word(input int addr, input logic [UIW-1:0] w);
        @(negedge clk);
        cs_wr_en = 1'b1; cs_wr_addr = AW'(addr); cs_wr_data = w;
        shadow[addr] = w;
        @(negedge clk);
        cs_wr_en = 1'b0;
    endtask

    // run one command; every broadcast word and mask is checked against the model
    task automatic run_kernel(input int start, input int len, input int cnt);
        int rem;
        int passes;
        @(negedge clk);
        cmd_start = AW'(start); cmd_count = CNT_W'(cnt); cmd_valid = 1'b1;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        // R7: busy right after acceptance
        check(!cmd_ready && !bc_valid && !done, "R7", {cmd_ready, bc_valid, done}, 0);
        if (cnt == 0) begin
            @(negedge clk);
            // R9: no broadcast, done in second cycle after the accepting edge
            check(done && !bc_valid, "R9", {done, bc_valid}, 2);
            @(negedge clk);
            check(!done && !bc_valid, "R9", {done, bc_valid}, 0);
            return;
        end
        rem = cnt;
        passes = 0;
        while (rem > 0) begin
            for (int j = 0; j < len; j++) begin
                logic [LANES-1:0] exp_m;
                @(negedge clk);
                exp_m = (rem >= LANES) ? '1 : LANES'((1 << rem) - 1);
                // R2 R3 R4: word order and content
                check(bc_valid && bc_word == shadow[start + j], "R3", bc_word, shadow[start + j]);
                // R6
                check(bc_lane_en == exp_m, "R6", bc_lane_en, exp_m);
                // R7
                check(!cmd_ready && !done, "R7", {cmd_ready, done}, 0);
            end
            rem = rem - LANES;
            passes = passes + 1;
        end
        @(negedge clk);
        // R5 R8: pass count ended exactly here, done pulse, ready back
        check(done && !bc_valid, "R5", {done, bc_valid}, 2);
        check(cmd_ready, "R8", cmd_ready, 1);
        @(negedge clk);
        check(!done && !bc_valid, "R8", {done, bc_valid}, 0);
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(cmd_ready && !bc_valid && !done, "R1", {cmd_ready, bc_valid, done}, 4);
        rst_n = 1'b1;
        @(negedge clk);
        check(cmd_ready && !bc_valid && !done, "R1", {cmd_ready, bc_valid, done}, 4);

        // preload: bit UIW-1 marks the body end, low bits carry the address
        for (int a = 0; a < DEPTH; a++) begin
            logic le;
            le = 1'b0;
            for (int v = 0; v < NVEC; v++)
                if (a == int'(VEC[v][31:24]) + int'(VEC[v][23:16]) - 1) le = 1'b1;
            write_word(a, {le, 9'(a * 3), 6'(a)});
        end

        // table walk: various body lengths and record counts
        for (int v = 0; v < NVEC; v++)
            run_kernel(int'(VEC[v][31:24]), int'(VEC[v][23:16]), int'(VEC[v][15:0]));

        // R9: zero-record command
        run_kernel(4, 2, 0);

        // R2: rewrite a word, then the kernel must broadcast the new content
        write_word(8, 16'hC0DE);
        run_kernel(8, 1, 9);

        // R7: command offered while busy is not taken before done
        @(negedge clk);
        cmd_start = AW'(0); cmd_count = CNT_W'(16); cmd_valid = 1'b1;
        @(negedge clk);
        cmd_start = AW'(30); cmd_count = CNT_W'(3);
        @(negedge clk);
        check(!cmd_ready, "R7", cmd_ready, 0);
        cmd_valid = 1'b0;
        // body 0..2 runs two passes: 6 words, first at the second cycle after accept
        for (int k = 0; k < 6; k++) begin
            check(bc_valid && bc_word == shadow[k % 3], "R4", bc_word, shadow[k % 3]);
            @(negedge clk);
        end
        check(done && !bc_valid, "R8", {done, bc_valid}, 2);
        @(negedge clk);
        check(!bc_valid && !done, "R7", {bc_valid, done}, 0);

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule